// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block walks a fractional PLL through a safe frequency change. A request gives an integer frequency in MHz and a remainder in Hz. On an accepted start the block drops the PLL's run control, which puts it in standby, and polls the lock indicator until it reads low. It then writes four configuration words: the divider settings, the fractional word, the integer word and the spread value. Next it raises the run control together with both spread-spectrum enables and polls until lock reads high.

Lock is sampled once every `POLL_US` microsecond ticks. Each wait has a budget of `TIMEOUT_US` microseconds. If a wait runs out of budget, the sequence is abandoned with an error flag and a done pulse. The fractional word is worked out on the chip by a bit-serial divider. That divider runs while the block is waiting for the PLL to unlock.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset the four configuration outputs are 0, `pll_run_o` is 1, `ssc_en_o`, `dspread_en_o`, `done_o` and `err_o` are 0.
- R2: When `start_i` is seen while the block is idle, `pll_run_o` goes to 0 (standby) and `err_o` goes to 0 on the next cycle.
- R3: In standby, lock is sampled on every `POLL_US`-th microsecond tick. The configuration outputs keep their old values until a sample finds lock at 0.
- R4: The divider word `cfg_div_o` is 0x211: post divider one = 1 in bits [2:0], post divider two = 1 in bits [6:4], reference divider = 2 in bits [13:8]. `cfg_spread_o` is 0x16.
- R5: `cfg_frac_o` holds floor(rem × 2^24 / 10^6) in bits [31:8], and bits [7:0] are 0. A remainder of 10^6 or more is treated as 999999.
- R6: `cfg_int_o` holds the requested MHz value in bits [31:16]. Bit 0 is set to 1 and all other bits are 0.
- R7: After the configuration write, `pll_run_o`, `ssc_en_o` and `dspread_en_o` rise together. When a later tick sample finds lock at 1, `done_o` pulses with `err_o` at 0.
- R8: If a wait gets TIMEOUT_US/POLL_US samples without the condition it waits for, `err_o` goes to 1 and `done_o` pulses, and the block goes idle. After an unlock timeout the configuration outputs are unchanged and `pll_run_o` stays 0.
- R9: A `start_i` that arrives while a sequence is running has no effect on that sequence or on the values it writes.
- R10: `done_o` lasts exactly one cycle. `err_o` holds until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a reprogramming sequence |
| mhz_i | input | INT_W | Requested integer frequency in MHz |
| rem_hz_i | input | REM_W | Requested remainder below 1 MHz, in Hz |
| lock_i | input | 1 | PLL lock indicator |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| cfg_div_o | output | 32 | Divider configuration word |
| cfg_frac_o | output | 32 | Fractional configuration word |
| cfg_int_o | output | 32 | Integer configuration word |
| cfg_spread_o | output | 32 | Spread configuration word |
| pll_run_o | output | 1 | 1 = PLL runs, 0 = standby |
| ssc_en_o | output | 1 | Spread-spectrum enable |
| dspread_en_o | output | 1 | Downspread enable |
| done_o | output | 1 | One-cycle sequence-end pulse |
| err_o | output | 1 | Last sequence timed out |

## Verification
The bench keeps a behavioural model of the sequence and compares every output on every cycle. The lock stub is run in three ways, and each drives a different exit path:
- A lock that follows the run control after a delay exercises the full path.
- A lock stuck high must end in an unlock timeout with no configuration write.
- A lock stuck low must end in a lock timeout after the write.

Remainders of 0, one half, 999999 and exactly 10^6 separate correct fractional arithmetic and clamping from truncation errors. A second start sent in the middle of a sequence shows whether the block latches the new request.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_UNLOCK,
      ST_DIVWAIT,
      ST_RUN,
      ST_LOCK
   } seq_state_t;

   localparam int          HZ_PER_MHZ = 1000000;
   localparam int          FRAC_W     = 24;
   localparam logic [2:0]  POSTDIV_A  = 3'd1;
   localparam logic [2:0]  POSTDIV_B  = 3'd1;
   localparam logic [5:0]  REFDIV     = 6'd2;
   localparam logic [7:0]  SPREAD     = 8'h16;

   function automatic logic [31:0] pack_div_word();
      logic [31:0] w;
      w        = '0;
      w[2:0]   = POSTDIV_A;
      w[6:4]   = POSTDIV_B;
      w[13:8]  = REFDIV;
      return w;
   endfunction

   function automatic logic [31:0] pack_frac_word(input logic [FRAC_W-1:0] f);
      return {f, 8'h00};
   endfunction

   function automatic logic [31:0] pack_int_word(input logic [15:0] mhz);
      return {mhz, 15'd0, 1'b1};
   endfunction

endpackage

// File: rtl/frac_divider.sv
module frac_divider #(
   parameter int REM_W   = 20,
   parameter int Q_W     = 24,
   parameter int DIVISOR = 1000000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [REM_W-1:0] rem,
   output logic             ready,
   output logic [Q_W-1:0]   quo
);
   localparam int R_W   = $clog2(DIVISOR) + 1;
   localparam int CNT_W = $clog2(Q_W + 1);

   logic [R_W-1:0]   rem_c;
   logic [R_W-1:0]   part_q;
   logic [R_W:0]     dbl;
   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;

   always_comb begin
      rem_c = (32'(rem) >= 32'(DIVISOR)) ? R_W'(DIVISOR - 1) : R_W'(rem);
      dbl   = {part_q, 1'b0};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         part_q <= '0;
         quo    <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (go) begin
         part_q <= rem_c;
         quo    <= '0;
         cnt_q  <= CNT_W'(Q_W);
         busy_q <= 1'b1;
      end else if (busy_q) begin
         if (dbl >= (R_W+1)'(DIVISOR)) begin
            part_q <= R_W'(dbl - (R_W+1)'(DIVISOR));
            quo    <= {quo[Q_W-2:0], 1'b1};
         end else begin
            part_q <= R_W'(dbl);
            quo    <= {quo[Q_W-2:0], 1'b0};
         end
         cnt_q <= cnt_q - 1'b1;
         if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
      end
   end

   assign ready = !busy_q;

endmodule

// File: rtl/poll_timer.sv
module poll_timer #(
   parameter int POLL_US = 100,
   parameter int NPOLL   = 2500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic us_tick,
   output logic poll_now,
   output logic poll_last
);
   localparam int TW = (POLL_US > 1) ? $clog2(POLL_US) : 1;
   localparam int PW = (NPOLL > 1) ? $clog2(NPOLL) : 1;

   logic [TW-1:0] tick_q;
   logic [PW-1:0] poll_q;
   logic          at_edge;

   assign at_edge   = (tick_q == TW'(POLL_US - 1));
   assign poll_now  = enable && us_tick && at_edge;
   assign poll_last = (poll_q == PW'(NPOLL - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_q <= '0;
         poll_q <= '0;
      end else if (!enable) begin
         tick_q <= '0;
         poll_q <= '0;
      end else if (us_tick) begin
         if (at_edge) begin
            tick_q <= '0;
            poll_q <= poll_q + 1'b1;
         end else begin
            tick_q <= tick_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
   import pll_seq_pkg::*;
#(
   parameter int INT_W      = 8,
   parameter int REM_W      = 20,
   parameter int POLL_US    = 100,
   parameter int TIMEOUT_US = 250000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [INT_W-1:0] mhz_i,
   input  logic [REM_W-1:0] rem_hz_i,
   input  logic             lock_i,
   input  logic             us_tick_i,
   output logic [31:0]      cfg_div_o,
   output logic [31:0]      cfg_frac_o,
   output logic [31:0]      cfg_int_o,
   output logic [31:0]      cfg_spread_o,
   output logic             pll_run_o,
   output logic             ssc_en_o,
   output logic             dspread_en_o,
   output logic             done_o,
   output logic             err_o
);
   localparam int NPOLL = TIMEOUT_US / POLL_US;

   if (INT_W < 1 || INT_W > 16) begin : g_bad_int_w
      $error("INT_W must lie in 1..16");
   end
   if (REM_W < 1 || REM_W > 31) begin : g_bad_rem_w
      $error("REM_W must lie in 1..31");
   end
   if (POLL_US < 1 || TIMEOUT_US < POLL_US) begin : g_bad_poll
      $error("need 1 <= POLL_US <= TIMEOUT_US");
   end

   seq_state_t        state_q;
   logic [INT_W-1:0]  mhz_q;
   logic              accept;
   logic              in_wait;
   logic              poll_now;
   logic              poll_last;
   logic              div_ready;
   logic [FRAC_W-1:0] frac;

   assign accept  = start_i && (state_q == ST_IDLE);
   assign in_wait = (state_q == ST_UNLOCK) || (state_q == ST_LOCK);

   frac_divider #(
      .REM_W  (REM_W),
      .Q_W    (FRAC_W),
      .DIVISOR(HZ_PER_MHZ)
   ) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .go   (accept),
      .rem  (rem_hz_i),
      .ready(div_ready),
      .quo  (frac)
   );

   poll_timer #(
      .POLL_US(POLL_US),
      .NPOLL  (NPOLL)
   ) u_poll (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (in_wait),
      .us_tick  (us_tick_i),
      .poll_now (poll_now),
      .poll_last(poll_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         mhz_q        <= '0;
         cfg_div_o    <= '0;
         cfg_frac_o   <= '0;
         cfg_int_o    <= '0;
         cfg_spread_o <= '0;
         pll_run_o    <= 1'b1;
         ssc_en_o     <= 1'b0;
         dspread_en_o <= 1'b0;
         done_o       <= 1'b0;
         err_o        <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  mhz_q     <= mhz_i;
                  pll_run_o <= 1'b0;
                  err_o     <= 1'b0;
                  state_q   <= ST_UNLOCK;
               end
            end
            ST_UNLOCK: begin
               if (poll_now) begin
                  if (!lock_i) begin
                     state_q <= ST_DIVWAIT;
                  end else if (poll_last) begin
                     err_o   <= 1'b1;
                     done_o  <= 1'b1;
                     state_q <= ST_IDLE;
                  end
               end
            end
            ST_DIVWAIT: begin
               if (div_ready) begin
                  cfg_div_o    <= pack_div_word();
                  cfg_frac_o   <= pack_frac_word(frac);
                  cfg_int_o    <= pack_int_word(16'(mhz_q));
                  cfg_spread_o <= {24'd0, SPREAD};
                  state_q      <= ST_RUN;
               end
            end
            ST_RUN: begin
               pll_run_o    <= 1'b1;
               ssc_en_o     <= 1'b1;
               dspread_en_o <= 1'b1;
               state_q      <= ST_LOCK;
            end
            ST_LOCK: begin
               if (poll_now) begin
                  if (lock_i) begin
                     done_o  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else if (poll_last) begin
                     err_o   <= 1'b1;
                     done_o  <= 1'b1;
                     state_q <= ST_IDLE;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/pll_reprog_seq_chk.sv
module pll_reprog_seq_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        start_i,
   input logic        lock_i,
   input logic [31:0] cfg_int_o,
   input logic        pll_run_o,
   input logic        ssc_en_o,
   input logic        dspread_en_o,
   input logic        done_o,
   input logic        err_o
);

   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> done_o);

   a_r2_standby_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pll_run_o) |-> $past(start_i));

   a_r3_cfg_only_in_standby: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_int_o) |-> !pll_run_o);

   a_r7_normal_mode: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll_run_o) |-> (ssc_en_o && dspread_en_o));

   a_r7_locked_done: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !err_o) |-> (pll_run_o && $past(lock_i)));

endmodule

bind pll_reprog_seq pll_reprog_seq_chk u_chk (.*);

// File: tb/sim_pll_reprog_seq.sv
`timescale 1ns/1ps
module sim_pll_reprog_seq;
   localparam int INT_W = 8;
   localparam int REM_W = 20;
   localparam int P     = 3;
   localparam int T     = 30;
   localparam int N     = T / P;
   localparam int LAT   = 7;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [INT_W-1:0] mhz = '0;
   logic [REM_W-1:0] rem = '0;
   logic             lock = 1'b1;
   logic             tick = 1'b0;
   logic [31:0]      cfg_div, cfg_frac, cfg_int, cfg_spread;
   logic             run, ssc, dsp, done, err;

   int n_cmp = 0;
   int n_bad = 0;
   int lock_mode = 0;
   bit cmp_on = 1'b0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   pll_reprog_seq #(.INT_W(INT_W), .REM_W(REM_W), .POLL_US(P), .TIMEOUT_US(T)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .mhz_i(mhz), .rem_hz_i(rem),
      .lock_i(lock), .us_tick_i(tick), .cfg_div_o(cfg_div), .cfg_frac_o(cfg_frac),
      .cfg_int_o(cfg_int), .cfg_spread_o(cfg_spread), .pll_run_o(run),
      .ssc_en_o(ssc), .dspread_en_o(dsp), .done_o(done), .err_o(err));

   function automatic logic [31:0] exp_frac_word(input longint r);
      longint rr;
      longint q;
      rr = (r >= 1000000) ? 999999 : r;
      q  = (rr * 64'd16777216) / 1000000;
      return 32'(q) << 8;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- reference model ----------------
   int          m_st = 0;
   int          m_tick = 0, m_poll = 0, m_divleft = 0;
   longint      m_mhz = 0, m_rem = 0;
   logic [31:0] m_div = 0, m_frac = 0, m_int = 0, m_spr = 0;
   logic        m_run = 1, m_ssc = 0, m_dsp = 0, m_done = 0, m_err = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_tick = 0; m_poll = 0; m_divleft = 0;
         m_div = 0; m_frac = 0; m_int = 0; m_spr = 0;
         m_run = 1; m_ssc = 0; m_dsp = 0; m_done = 0; m_err = 0;
      end else begin
         bit started;
         bit is_poll;
         started = 0;
         m_done  = 0;
         if (m_st != 1 && m_st != 4) begin
            m_tick = 0; m_poll = 0;
         end
         is_poll = 0;
         if ((m_st == 1 || m_st == 4) && tick) begin
            if (m_tick == P - 1) begin
               is_poll = 1; m_tick = 0;
            end else m_tick++;
         end
         case (m_st)
            0: if (start) begin
                  m_mhz = mhz; m_rem = rem; m_run = 0; m_err = 0;
                  started = 1; m_st = 1;
               end
            1: if (is_poll) begin
                  if (!lock) m_st = 2;
                  else if (m_poll == N - 1) begin m_err = 1; m_done = 1; m_st = 0; end
                  m_poll++;
               end
            2: if (m_divleft == 0) begin
                  m_div = 32'h211; m_spr = 32'h16;
                  m_frac = exp_frac_word(m_rem);
                  m_int = (32'(m_mhz) << 16) | 32'h1;
                  m_st = 3;
               end
            3: begin m_run = 1; m_ssc = 1; m_dsp = 1; m_st = 4; end
            4: if (is_poll) begin
                  if (lock) begin m_done = 1; m_st = 0; end
                  else if (m_poll == N - 1) begin m_err = 1; m_done = 1; m_st = 0; end
                  m_poll++;
               end
            default: m_st = 0;
         endcase
         if (started) m_divleft = 24;
         else if (m_divleft > 0) m_divleft--;
      end
   end

   always @(negedge clk) begin
      if (rst_n && cmp_on && !finished) begin
         chk("R4 div", cfg_div, m_div);
         chk("R5 frac", cfg_frac, m_frac);
         chk("R6 int", cfg_int, m_int);
         chk("R4 spread", cfg_spread, m_spr);
         chk("R2 run", {31'd0, run}, {31'd0, m_run});
         chk("R7 ssc", {31'd0, ssc}, {31'd0, m_ssc});
         chk("R7 dspread", {31'd0, dsp}, {31'd0, m_dsp});
         chk("R10 done", {31'd0, done}, {31'd0, m_done});
         chk("R8 err", {31'd0, err}, {31'd0, m_err});
      end
   end

   // ---------------- tick and lock stub ----------------
   int tdiv = 0;
   int lcnt = 0;
   always @(negedge clk) begin
      tdiv = (tdiv + 1) % 2;
      tick <= (tdiv == 0);
      case (lock_mode)
         1: lock <= 1'b1;
         2: lock <= 1'b0;
         default: begin
            if (lock != run) begin
               lcnt++;
               if (lcnt >= LAT) begin lock <= run; lcnt = 0; end
            end else lcnt = 0;
         end
      endcase
   end

   // ---------------- watchdog ----------------
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !finished) begin
         finished = 1'b1;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic kick(input int m, input int r);
      @(negedge clk);
      start = 1'b1; mhz = INT_W'(m); rem = REM_W'(r);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (done) return;
      end
   endtask

   task automatic run_ok(input int m, input int r, input string req);
      kick(m, r);
      wait_done();
      chk({req, " done"}, {31'd0, done}, 32'd1);
      chk({req, " err clear"}, {31'd0, err}, 32'd0);
      chk({req, " frac word"}, cfg_frac, exp_frac_word(r));
      chk({req, " int word"}, cfg_int, (32'(m) << 16) | 32'h1);
      chk("R4 div word", cfg_div, 32'h211);
      chk("R7 normal", {29'd0, run, ssc, dsp}, 32'd7);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset cfg", cfg_div | cfg_frac | cfg_int | cfg_spread, 32'd0);
      chk("R1 reset ctrl", {27'd0, run, ssc, dsp, done, err}, 32'b10000);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      repeat (3) @(negedge clk);

      run_ok(148, 500000, "R5 R6 half");
      run_ok(33, 0, "R5 R6 zero");
      run_ok(255, 999999, "R5 R6 top");
      run_ok(10, 1000000, "R5 clamp");

      // R9: second start mid-sequence ignored
      kick(100, 123456);
      repeat (10) @(negedge clk);
      start = 1'b1; mhz = 8'd7; rem = 20'd7;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      chk("R9 int kept", cfg_int, 32'h0064_0001);
      chk("R9 frac kept", cfg_frac, exp_frac_word(123456));

      // R8 R3: unlock timeout, lock stuck high
      lock_mode = 1;
      kick(50, 1);
      wait_done();
      chk("R8 unlock err", {31'd0, err}, 32'd1);
      chk("R3 cfg unchanged", cfg_int, 32'h0064_0001);
      chk("R8 stays standby", {31'd0, run}, 32'd0);

      // R8: lock timeout after configuration, lock stuck low
      lock_mode = 0;
      repeat (12) @(negedge clk);
      lock_mode = 2;
      kick(60, 250000);
      wait_done();
      chk("R8 lock err", {31'd0, err}, 32'd1);
      chk("R8 cfg written", cfg_int, 32'h003C_0001);
      chk("R8 running", {31'd0, run}, 32'd1);

      // R10: err holds until next start
      lock_mode = 0;
      repeat (20) @(negedge clk);
      chk("R10 err held", {31'd0, err}, 32'd1);
      chk("R10 done low", {31'd0, done}, 32'd0);
      run_ok(200, 750000, "R10 R2 recover");

      repeat (5) @(negedge clk);
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule